// File: doc/BRIEF.md
# Host Command Register File

This block sits between a host computer and a set of drawing engines. The host reaches it through a byte-wide parallel port. The port's electrical handshake is reduced here to single-cycle synchronous strobes. An address cycle loads an 8-bit selector register. Each later data cycle then writes or reads the byte register that the selector names. Only an address cycle changes the selector, so the host can issue many data cycles to one location without loading it again.

Twenty parameter bytes hold the arguments of a command. One further location accepts a command byte. A recognised command whose engine is idle starts that engine with a one-cycle pulse. One more location returns a status byte: a command error flag and the idle flag of each engine. While an engine runs it can return results through a writeback port into the parameter bytes. The host then reads those results back, for example the fetched data of a block read.

Top module: `hostcmd_regfile`

## Requirements
- R1: An address cycle (`host_addr_wr` high) loads `host_wdata` into the selector on that clock edge. No other input changes the selector.
- R2: A data write with the selector at 0 to 19 stores `host_wdata` in that parameter byte. `host_rdata` shows the byte at the selector combinationally.
- R3: Reading selector 20 returns 0x00. Reading any selector of 22 or above returns 0x00. Data writes to selectors 21 and above change no register.
- R4: Reading selector 21 returns the status byte. Bit 7 is the error flag. Bits 6, 5, 4 and 3 are the idle flags of block reader (`fu_idle[0]`), block writer (`fu_idle[1]`), block set (`fu_idle[2]`) and polygon scanline (`fu_idle[3]`). Bits 2 to 0 are zero.
- R5: A data write of a recognised code to selector 20 raises exactly one `fu_start` bit for the single cycle after the write edge. The codes are 0x0F for the reader (bit 0), 0xF0 for the writer (bit 1), 0x03 for block set (bit 2) and 0x30 for scanline (bit 3).
- R6: Any other command byte, including 0x04 (line draw, which has no engine), sets the error flag and raises no `fu_start` bit.
- R7: A recognised command whose engine has its idle flag low sets the error flag and raises no `fu_start` bit.
- R8: An accepted command clears the error flag.
- R9: A writeback (`fu_wr_en` high) stores `fu_wr_data` in parameter byte `fu_wr_idx`. If the host writes the same byte in the same cycle, the writeback value is the one kept.
- R10: After reset the selector, all parameter bytes and the error flag are zero, and no `fu_start` bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr_wr | input | 1 | Address cycle strobe |
| host_data_wr | input | 1 | Data write strobe |
| host_wdata | input | 8 | Byte from the host |
| host_rdata | output | 8 | Byte at the current selector |
| fu_idle | input | 4 | Idle flag of each engine |
| fu_start | output | 4 | One-cycle start pulse to each engine |
| fu_wr_en | input | 1 | Engine writeback strobe |
| fu_wr_idx | input | 5 | Parameter byte targeted by the writeback |
| fu_wr_data | input | 8 | Writeback byte |

## Verification
The properties assume that a writeback index lies below 20. The stimulus therefore draws writeback indices only from 0 to 19. It never raises an address strobe and a data strobe in the same cycle, so each data cycle acts on a selector that is already settled. Idle flags change only between host cycles, never on the command edge itself. Commands are steered to selector 20 often enough that the accept, busy-reject and unknown-code paths are all exercised with random idle patterns.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_PARAM = 20;
    localparam int NUM_FU    = 4;
    localparam int IDX_W     = $clog2(NUM_PARAM);

    // Selector values for the command and status locations follow the parameter bytes.
    localparam logic [REG_W-1:0] CMD_ADDR  = REG_W'(NUM_PARAM);
    localparam logic [REG_W-1:0] STAT_ADDR = REG_W'(NUM_PARAM + 1);

    // Command code per engine: reader, writer, block set, scanline.
    localparam logic [REG_W-1:0] CMD_CODE [NUM_FU] = '{8'h0F, 8'hF0, 8'h03, 8'h30};

    typedef struct packed {
        logic [REG_W-1:0]  addr;
        logic              err;
        logic [NUM_FU-1:0] start;
    } ctl_t;
endpackage

// File: rtl/hostcmd_decode.sv
module hostcmd_decode
    import hostcmd_pkg::*;
(
    input  logic [REG_W-1:0]  code,
    output logic [NUM_FU-1:0] hit,
    output logic              valid
);
    // 0x04 and every other unlisted byte match no engine.
    for (genvar i = 0; i < NUM_FU; i++) begin : g_code
        assign hit[i] = (code == CMD_CODE[i]);
    end
    assign valid = |hit;
endmodule

// File: rtl/hostcmd_param_bank.sv
module hostcmd_param_bank
    import hostcmd_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             host_we,
    input  logic [IDX_W-1:0]                 host_idx,
    input  logic [REG_W-1:0]                 host_data,
    input  logic                             fu_we,
    input  logic [IDX_W-1:0]                 fu_idx,
    input  logic [REG_W-1:0]                 fu_data,
    output logic [NUM_PARAM-1:0][REG_W-1:0]  regs
);
    for (genvar i = 0; i < NUM_PARAM; i++) begin : g_reg
        logic [REG_W-1:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (host_we && host_idx == IDX_W'(i)) reg_d = host_data;
            // Applied last so the engine wins a same-cycle collision.
            if (fu_we && fu_idx == IDX_W'(i))     reg_d = fu_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q <= '0;
            else        reg_q <= reg_d;
        end

        assign regs[i] = reg_q;
    end
endmodule

// File: rtl/hostcmd_read_mux.sv
module hostcmd_read_mux
    import hostcmd_pkg::*;
(
    input  logic [REG_W-1:0]                addr,
    input  logic [NUM_PARAM-1:0][REG_W-1:0] regs,
    input  logic [REG_W-1:0]                status,
    output logic [REG_W-1:0]                rdata
);
    always_comb begin
        rdata = '0;
        if (addr < CMD_ADDR)        rdata = regs[addr[IDX_W-1:0]];
        else if (addr == STAT_ADDR) rdata = status;
    end
endmodule

// File: rtl/hostcmd_regfile.sv
module hostcmd_regfile
    import hostcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_addr_wr,
    input  logic                host_data_wr,
    input  logic [REG_W-1:0]    host_wdata,
    output logic [REG_W-1:0]    host_rdata,
    input  logic [NUM_FU-1:0]   fu_idle,
    output logic [NUM_FU-1:0]   fu_start,
    input  logic                fu_wr_en,
    input  logic [IDX_W-1:0]    fu_wr_idx,
    input  logic [REG_W-1:0]    fu_wr_data
);
    ctl_t ctl_d, ctl_q;

    logic [NUM_FU-1:0]              dec_hit;
    logic                           dec_valid;
    logic [NUM_PARAM-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0]               status;
    logic [REG_W-1:0]               addr_q;
    logic                           err_q;
    logic                           param_we;

    assign addr_q   = ctl_q.addr;
    assign err_q    = ctl_q.err;
    assign param_we = host_data_wr && (addr_q < CMD_ADDR);

    hostcmd_decode u_dec (
        .code  (host_wdata),
        .hit   (dec_hit),
        .valid (dec_valid)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = '0;
        if (host_addr_wr) ctl_d.addr = host_wdata;
        if (host_data_wr && addr_q == CMD_ADDR) begin
            if (!dec_valid)                  ctl_d.err = 1'b1;
            else if ((dec_hit & fu_idle) == '0) ctl_d.err = 1'b1;
            else begin
                ctl_d.err   = 1'b0;
                ctl_d.start = dec_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    hostcmd_param_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (param_we),
        .host_idx  (addr_q[IDX_W-1:0]),
        .host_data (host_wdata),
        .fu_we     (fu_wr_en),
        .fu_idx    (fu_wr_idx),
        .fu_data   (fu_wr_data),
        .regs      (regs)
    );

    // Error on top, then idle flags from engine 0 downward, unused bits zero.
    always_comb begin
        status          = '0;
        status[REG_W-1] = err_q;
        for (int i = 0; i < NUM_FU; i++) status[REG_W-2-i] = fu_idle[i];
    end

    hostcmd_read_mux u_rd (
        .addr   (addr_q),
        .regs   (regs),
        .status (status),
        .rdata  (host_rdata)
    );

    assign fu_start = ctl_q.start;
endmodule

// File: rtl/hostcmd_regfile_chk.sv
module hostcmd_regfile_chk
    import hostcmd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                host_addr_wr,
    input logic                host_data_wr,
    input logic [REG_W-1:0]    host_wdata,
    input logic [REG_W-1:0]    host_rdata,
    input logic [NUM_FU-1:0]   fu_idle,
    input logic [NUM_FU-1:0]   fu_start,
    input logic                fu_wr_en,
    input logic [IDX_W-1:0]    fu_wr_idx,
    input logic [REG_W-1:0]    fu_wr_data,
    input logic [REG_W-1:0]    addr_q,
    input logic                err_q
);
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_addr_wr |=> (addr_q == $past(addr_q)));

    p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr_wr |=> (addr_q == $past(host_wdata)));

    p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == CMD_ADDR) |-> (host_rdata == '0));

    p_status_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == STAT_ADDR) |-> (host_rdata[2:0] == 3'b000));

    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_start));

    p_start_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_start != '0) |-> $past(host_data_wr && addr_q == CMD_ADDR));

    p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_start != '0) |-> ((fu_start & ~$past(fu_idle)) == '0));

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_start != '0) |-> !err_q);

    p_fu_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_wr_en && !host_addr_wr && fu_wr_idx < IDX_W'(NUM_PARAM)
         && REG_W'(fu_wr_idx) == addr_q) |=> (host_rdata == $past(fu_wr_data)));
endmodule

bind hostcmd_regfile hostcmd_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr_wr (host_addr_wr),
    .host_data_wr (host_data_wr),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .fu_idle      (fu_idle),
    .fu_start     (fu_start),
    .fu_wr_en     (fu_wr_en),
    .fu_wr_idx    (fu_wr_idx),
    .fu_wr_data   (fu_wr_data),
    .addr_q       (addr_q),
    .err_q        (err_q)
);

// File: tb/sim_hostcmd_regfile.sv
`timescale 1ns/1ps
module sim_hostcmd_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr_wr = 1'b0;
    logic       host_data_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [3:0] fu_idle = 4'hF;
    logic [3:0] fu_start;
    logic       fu_wr_en = 1'b0;
    logic [4:0] fu_wr_idx = '0;
    logic [7:0] fu_wr_data = '0;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_par [20];
    logic [7:0] m_addr;
    logic       m_err;
    logic [3:0] m_start;

    always #4 clk = ~clk;

    hostcmd_regfile u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        if (m_addr < 8'd20)  return m_par[m_addr[4:0]];
        if (m_addr == 8'd21) return {m_err, fu_idle[0], fu_idle[1], fu_idle[2], fu_idle[3], 3'b000};
        return 8'h00;
    endfunction

    function automatic int code_unit(input logic [7:0] c);
        case (c)
            8'h0F: return 0;
            8'hF0: return 1;
            8'h03: return 2;
            8'h30: return 3;
            default: return -1;
        endcase
    endfunction

    // One host/engine cycle, started and ended at a falling edge; the model is updated from pre-edge state.
    task automatic step(input logic aw, input logic dw, input logic [7:0] wd,
                        input logic fwe, input logic [4:0] fidx, input logic [7:0] fdat);
        int u;
        host_addr_wr = aw; host_data_wr = dw; host_wdata = wd;
        fu_wr_en = fwe; fu_wr_idx = fidx; fu_wr_data = fdat;
        @(negedge clk);
        host_addr_wr = 1'b0; host_data_wr = 1'b0; fu_wr_en = 1'b0;
        m_start = '0;
        if (dw) begin
            if (m_addr < 8'd20 && !(fwe && fidx == m_addr[4:0])) m_par[m_addr[4:0]] = wd;
            if (m_addr == 8'd20) begin
                u = code_unit(wd);
                if (u < 0)             m_err = 1'b1;
                else if (!fu_idle[u])  m_err = 1'b1;
                else begin m_err = 1'b0; m_start = 4'(1 << u); end
            end
        end
        if (aw) m_addr = wd;
        if (fwe) m_par[fidx] = fdat;
    endtask

    task automatic set_addr(input logic [7:0] a);
        step(1'b1, 1'b0, a, 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [7:0] d);
        step(1'b0, 1'b1, d, 1'b0, '0, '0);
    endtask

    task automatic read_at(input string tag, input logic [7:0] a);
        set_addr(a);
        chk(tag, host_rdata, exp_rdata());
    endtask

    task automatic cmd(input string tag, input logic [7:0] c, input logic [3:0] idle);
        fu_idle = idle;
        set_addr(8'd20);
        wr(c);
        chk({tag, " start"}, {4'h0, fu_start}, {4'h0, m_start});
        @(negedge clk);
        chk({tag, " pulse ends"}, {4'h0, fu_start}, 8'h00);
        read_at({tag, " status"}, 8'd21);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        foreach (m_par[i]) m_par[i] = '0;
        m_addr = '0; m_err = 1'b0; m_start = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 start after reset", {4'h0, fu_start}, 8'h00);
        chk("R10 param0 after reset", host_rdata, 8'h00);
        read_at("R10 status after reset", 8'd21);
        read_at("R10 param19 after reset", 8'd19);

        // R1 / R2 write and read back
        set_addr(8'd7);
        wr(8'hA5);
        chk("R2 param7 readback", host_rdata, 8'hA5);
        wr(8'h5A);
        chk("R1 selector kept across data writes", host_rdata, 8'h5A);
        set_addr(8'd0); wr(8'h11);
        read_at("R2 param7 intact", 8'd7);
        read_at("R2 param0", 8'd0);

        // R3 command location reads zero, writes above 20 ignored
        read_at("R3 cmd reads zero", 8'd20);
        set_addr(8'd21); wr(8'hFF);
        chk("R3 status write ignored", host_rdata, exp_rdata());
        set_addr(8'd25); wr(8'h77);
        chk("R3 high selector reads zero", host_rdata, 8'h00);
        read_at("R3 params untouched", 8'd7);

        // R4 status layout with a distinct idle pattern
        fu_idle = 4'b1010;
        read_at("R4 status idle 1010", 8'd21);

        // R5 each code
        cmd("R5 reader 0F", 8'h0F, 4'hF);
        cmd("R5 writer F0", 8'hF0, 4'hF);
        cmd("R5 set 03", 8'h03, 4'hF);
        cmd("R5 scanline 30", 8'h30, 4'hF);
        // R6 line draw and unknown
        cmd("R6 line draw 04", 8'h04, 4'hF);
        cmd("R6 unknown 55", 8'h55, 4'hF);
        // R8 valid clears error
        cmd("R8 accept clears error", 8'h03, 4'hF);
        // R7 busy target
        cmd("R7 busy writer", 8'hF0, 4'b1101);
        cmd("R7 busy scanline", 8'h30, 4'b0111);
        cmd("R8 accept after busy", 8'h0F, 4'b0001);

        // R9 writeback and collision
        step(1'b0, 1'b0, 8'h00, 1'b1, 5'd12, 8'hC3);
        read_at("R9 writeback stored", 8'd12);
        set_addr(8'd5);
        step(1'b0, 1'b1, 8'h01, 1'b1, 5'd5, 8'hBE);
        chk("R9 engine wins collision", host_rdata, 8'hBE);
        step(1'b0, 1'b1, 8'h22, 1'b1, 5'd9, 8'h99);
        chk("R9 host write on other index", host_rdata, 8'h22);
        read_at("R9 engine write other index", 8'd9);

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [7:0] c;
            op = int'($urandom % 6);
            case (op)
                0: begin set_addr(8'($urandom % 24)); chk("R1 random select", host_rdata, exp_rdata()); end
                1: begin wr(8'($urandom)); chk("R2 random write", host_rdata, exp_rdata()); end
                2: begin
                    case ($urandom % 6)
                        0: c = 8'hF0; 1: c = 8'h0F; 2: c = 8'h03; 3: c = 8'h30;
                        4: c = 8'h04; default: c = 8'($urandom);
                    endcase
                    set_addr(8'd20);
                    wr(c);
                    chk("R5 random command", {4'h0, fu_start}, {4'h0, m_start});
                    set_addr(8'd21);
                    chk("R7 random status", host_rdata, exp_rdata());
                end
                3: begin
                    step(1'b0, 1'b0, 8'h00, 1'b1, 5'($urandom % 20), 8'($urandom));
                    chk("R9 random writeback", host_rdata, exp_rdata());
                end
                4: begin
                    if (m_addr < 8'd20) begin
                        step(1'b0, 1'b1, 8'($urandom), 1'b1, m_addr[4:0], 8'($urandom));
                        chk("R9 random collision", host_rdata, exp_rdata());
                    end else begin
                        wr(8'($urandom));
                        chk("R3 random high write", host_rdata, exp_rdata());
                    end
                end
                default: begin
                    fu_idle = 4'($urandom);
                    @(negedge clk);
                    chk("R4 random idle", host_rdata, exp_rdata());
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule